// File: doc/BRIEF.md
# Capture/Compare/Pulse-Width Timer Channel

This block is one channel that sits beside a free-running timer and reuses a single timer-width data register for three kinds of job. A 4-bit mode field picks the job. In the capture modes the register records the timer value when the input pin has an edge. In the compare modes the register is a threshold, and a match drives the output pin, raises a flag or asks for a timer reset. In the pulse-width modes the low byte of the register, together with two extra control bits, forms a 10-bit duty value. That value is compared against an external 10-bit PWM count.

Software reaches the channel through a byte-wide register port. Address 0 is the control byte, address 1 is the low data byte and address 2 is the high data byte. The interrupt flag stays set until a clear strobe arrives. The timer, the PWM period counter and the interrupt controller all live outside this block.

Top module: `capcmp_channel`

## Requirements
- R1: Reads are combinational. Address 0 returns the control byte with bits 7:6 always zero, bits 5:4 the two low duty bits and bits 3:0 the mode. Address 1 returns data bits 7:0, address 2 returns data bits 15:8, and address 3 returns zero. Writes take effect at the clock edge.
- R2: After reset, and while the mode is 0000, the output pin is low, the duty latch is zero and no capture, match or flag occurs. A write that enters mode 0000 drives the pin low at that same edge.
- R3: In modes 0001 and 0011 the pin, the flag and the data register are untouched by pin edges and timer matches.
- R4: Mode 0101 loads the timer value on each rising edge of the input pin, and mode 0100 does the same on each falling edge. Each load sets the flag. The input passes two synchroniser flops and one previous-sample flop, so the load happens at the third clock edge after the pin changes, using the timer value present at that edge. A capture takes priority over a software data write in the same cycle.
- R5: Mode 0110 loads on every 4th rising edge and mode 0111 on every 16th. The edge counter clears on any write that changes the mode.
- R6: Mode 0010 inverts the pin on a compare match and sets the flag.
- R7: Entering mode 1000 drives the pin low and a match then forces it high. Entering mode 1001 drives the pin high and a match then forces it low. Both set the flag on a match. Entering a mode means a control write whose mode differs from the current one, and it wins over a match in the same cycle.
- R8: Mode 1010 sets only the flag on a match. Mode 1011 also drives the timer-reset output high for one cycle, the cycle after the match edge, when the special-event parameter is set.
- R9: A match is taken only on the first cycle in which the timer equals the register. A timer held at that value produces no further matches until equality is lost and then regained.
- R10: In modes 11xx the duty latch reloads from {data[7:0], control[5:4]} at each edge where the PWM count is zero. The pin is registered high when the PWM count is below the duty value in force for that count, and that value is the new one at count zero.
- R11: The flag stays set until the clear strobe. If a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerCount | input | 16 | Free-running timer value |
| pwmCount | input | 10 | PWM period count |
| pinIn | input | 1 | Asynchronous capture input |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 control, 1 data low, 2 data high) |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data |
| flagClr | input | 1 | Interrupt flag clear strobe |
| pinOut | output | 1 | Channel output pin |
| irqFlag | output | 1 | Sticky interrupt flag |
| timerReset | output | 1 | One-cycle timer reset request |

## Verification
The pin, the flag, the timer-reset strobe and the data register are all registered, so each changes at the edge where its qualifying condition is present and is visible one edge after the stimulus. The exception is a pin-edge capture, which lands at the third edge after the pin moves. Read data follows the read address with no delay. The bench drives inputs just after a rising edge. A behavioural model steps at each rising edge, and every output is compared against the model at the following falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int MODE_W = 4;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_OFF          = 4'b0000;
  localparam mode_t MODE_TOGGLE       = 4'b0010;
  localparam mode_t MODE_CAP_FALL     = 4'b0100;
  localparam mode_t MODE_CAP_RISE     = 4'b0101;
  localparam mode_t MODE_CAP_RISE4    = 4'b0110;
  localparam mode_t MODE_CAP_RISE16   = 4'b0111;
  localparam mode_t MODE_SET_ON_MATCH = 4'b1000;
  localparam mode_t MODE_CLR_ON_MATCH = 4'b1001;
  localparam mode_t MODE_FLAG_ONLY    = 4'b1010;
  localparam mode_t MODE_EVENT        = 4'b1011;

  // Strobes from control to datapath, valid for one clock edge
  typedef struct packed {
    logic pinLoad;    // load pinVal into the pin latch
    logic pinVal;
    logic pinToggle;  // invert the pin latch
    logic pwmActive;  // pin follows the duty comparison
    logic capture;    // load timer into data register
    logic setFlag;
    logic eventPulse; // request timer reset
    logic dutyClear;
  } strobe_t;

  function automatic logic isPwm(mode_t m);
    return m[3:2] == 2'b11;
  endfunction

  function automatic logic isCompare(mode_t m);
    return (m == MODE_TOGGLE) || (m[3:2] == 2'b10);
  endfunction
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE_A  = 4,
  parameter int PRESCALE_B  = 16,
  parameter bit HAS_EVENT   = 1'b1,
  localparam int PRE_W      = $clog2(PRESCALE_B)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerCount,
  input  logic [TIMER_W-1:0] dataReg,
  input  logic               pinIn,
  input  logic               ctrlWrEn,
  input  logic [5:0]         ctrlWrData,
  output mode_t              mode,
  output logic [1:0]         dcLow,
  output strobe_t            st
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic prevSample, riseEdge, fallEdge;
  logic prevEq, isEq, matchFirst, entry;
  logic [PRE_W-1:0] preCnt, preLimit;
  mode_t newMode;

  assign newMode    = ctrlWrData[3:0];
  assign entry      = ctrlWrEn && (newMode != mode);
  assign riseEdge   = syncQ[SYNC_STAGES-1] && !prevSample;
  assign fallEdge   = !syncQ[SYNC_STAGES-1] && prevSample;
  assign isEq       = (timerCount == dataReg);
  assign matchFirst = isEq && !prevEq;
  assign preLimit   = (mode == MODE_CAP_RISE4) ? PRE_W'(PRESCALE_A - 1)
                                               : PRE_W'(PRESCALE_B - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ      <= '0;
      prevSample <= 1'b0;
      prevEq     <= 1'b0;
      mode       <= MODE_OFF;
      dcLow      <= 2'b00;
    end else begin
      syncQ      <= {syncQ[SYNC_STAGES-2:0], pinIn};
      prevSample <= syncQ[SYNC_STAGES-1];
      prevEq     <= isEq;
      if (ctrlWrEn) begin
        mode  <= newMode;
        dcLow <= ctrlWrData[5:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (entry || mode == MODE_OFF) preCnt <= '0;
    else if ((mode == MODE_CAP_RISE4 || mode == MODE_CAP_RISE16) && riseEdge)
      preCnt <= (preCnt == preLimit) ? '0 : preCnt + 1'b1;
  end

  always_comb begin
    st = '0;
    case (mode)
      MODE_OFF:          begin st.pinLoad = 1'b1; st.pinVal = 1'b0; st.dutyClear = 1'b1; end
      MODE_TOGGLE:       st.pinToggle = matchFirst;
      MODE_CAP_FALL:     st.capture = fallEdge;
      MODE_CAP_RISE:     st.capture = riseEdge;
      MODE_CAP_RISE4,
      MODE_CAP_RISE16:   st.capture = riseEdge && (preCnt == preLimit);
      MODE_SET_ON_MATCH: begin st.pinLoad = matchFirst; st.pinVal = 1'b1; end
      MODE_CLR_ON_MATCH: begin st.pinLoad = matchFirst; st.pinVal = 1'b0; end
      MODE_EVENT:        st.eventPulse = matchFirst && HAS_EVENT;
      default: ;
    endcase
    st.pwmActive = isPwm(mode);
    st.setFlag   = st.capture || (isCompare(mode) && matchFirst);
    if (entry) begin
      if (newMode == MODE_OFF || newMode == MODE_SET_ON_MATCH) begin
        st.pinLoad = 1'b1; st.pinVal = 1'b0;
      end else if (newMode == MODE_CLR_ON_MATCH) begin
        st.pinLoad = 1'b1; st.pinVal = 1'b1;
      end
    end
  end

  assert_prescale_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_CAP_RISE4) |-> (preCnt < PRE_W'(PRESCALE_A)));
  assert_no_capture_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> !st.capture && !st.setFlag);
endmodule

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int PWM_W   = 10,
  localparam int BYTES  = TIMER_W / 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [TIMER_W-1:0] timerCount,
  input  logic [PWM_W-1:0]   pwmCount,
  input  logic [1:0]         dcLow,
  input  logic [BYTES-1:0]   dataWrEn,
  input  logic [7:0]         wrData,
  input  logic               flagClr,
  output logic [TIMER_W-1:0] dataReg,
  output logic               pinOut,
  output logic               irqFlag,
  output logic               timerReset
);
  logic [PWM_W-1:0] dutyLatched, dutyFresh, dutyNow;
  logic pwmZero, pwmHigh;

  assign dutyFresh = {dataReg[PWM_W-3:0], dcLow};
  assign pwmZero   = (pwmCount == '0);
  assign dutyNow   = pwmZero ? dutyFresh : dutyLatched;
  assign pwmHigh   = pwmCount < dutyNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataReg <= '0;
    else if (st.capture) dataReg <= timerCount;
    else begin
      for (int b = 0; b < BYTES; b++)
        if (dataWrEn[b]) dataReg[b*8 +: 8] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyLatched <= '0;
      pinOut      <= 1'b0;
      irqFlag     <= 1'b0;
      timerReset  <= 1'b0;
    end else begin
      if (st.dutyClear) dutyLatched <= '0;
      else if (st.pwmActive && pwmZero) dutyLatched <= dutyFresh;

      if (st.pinLoad) pinOut <= st.pinVal;
      else if (st.pwmActive) pinOut <= pwmHigh;
      else if (st.pinToggle) pinOut <= ~pinOut;

      if (st.setFlag) irqFlag <= 1'b1;
      else if (flagClr) irqFlag <= 1'b0;

      timerReset <= st.eventPulse;
    end
  end

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag);
  assert_event_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    timerReset |=> !timerReset);
endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel
  import capcmp_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int PWM_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int PRESCALE_A  = 4,
  parameter int PRESCALE_B  = 16,
  parameter bit HAS_EVENT   = 1'b1,
  localparam int BYTES      = TIMER_W / 8,
  localparam int ADDR_W     = $clog2(BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerCount,
  input  logic [PWM_W-1:0]   pwmCount,
  input  logic               pinIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [7:0]         wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [7:0]         rdData,
  input  logic               flagClr,
  output logic               pinOut,
  output logic               irqFlag,
  output logic               timerReset
);
  mode_t mode;
  logic [1:0] dcLow;
  strobe_t st;
  logic [TIMER_W-1:0] dataReg;
  logic ctrlWrEn;
  logic [BYTES-1:0] dataWrEn;

  assign ctrlWrEn = wrEn && (wrAddr == '0);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dataWrEn[b] = wrEn && (wrAddr == ADDR_W'(b + 1));
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) rdData = {2'b00, dcLow, mode};
    for (int b = 0; b < BYTES; b++)
      if (rdAddr == ADDR_W'(b + 1)) rdData = dataReg[b*8 +: 8];
  end

  capcmp_ctrl #(
    .TIMER_W(TIMER_W), .SYNC_STAGES(SYNC_STAGES), .PRESCALE_A(PRESCALE_A),
    .PRESCALE_B(PRESCALE_B), .HAS_EVENT(HAS_EVENT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .timerCount(timerCount), .dataReg(dataReg),
    .pinIn(pinIn), .ctrlWrEn(ctrlWrEn), .ctrlWrData(wrData[5:0]),
    .mode(mode), .dcLow(dcLow), .st(st)
  );

  capcmp_datapath #(.TIMER_W(TIMER_W), .PWM_W(PWM_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .timerCount(timerCount), .pwmCount(pwmCount),
    .dcLow(dcLow), .dataWrEn(dataWrEn), .wrData(wrData), .flagClr(flagClr),
    .dataReg(dataReg), .pinOut(pinOut), .irqFlag(irqFlag), .timerReset(timerReset)
  );

  assert_ctrl_upper_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == '0) |-> (rdData[7:6] == 2'b00));
  assert_off_pin_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && wrData[3:0] == MODE_OFF) |=> !pinOut);
  assert_reserved_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 4'b0001 || mode == 4'b0011) && !wrEn) |=> $stable(pinOut) && $stable(dataReg));
  assert_entry_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && wrData[3:0] == MODE_CLR_ON_MATCH && mode != MODE_CLR_ON_MATCH) |=> pinOut);
  assert_event_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    timerReset |-> ($past(mode) == MODE_EVENT));
endmodule

// File: tb/capcmp_channel_tb.sv
module capcmp_channel_tb;
  logic clk = 1'b0;
  logic rstN;
  logic [15:0] timerCount = 16'h0;
  logic [9:0] pwmCount = 10'h0;
  logic pinIn = 1'b0, wrEn = 1'b0, flagClr = 1'b0;
  logic [1:0] wrAddr = 2'd0, rdAddr = 2'd0;
  logic [7:0] wrData = 8'h0;
  logic [7:0] rdData;
  logic pinOut, irqFlag, timerReset;

  int checks = 0, errors = 0;
  string curReq = "R2";
  bit timerHold = 1'b0, started = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  capcmp_channel u_dut (
    .clk(clk), .rstN(rstN), .timerCount(timerCount), .pwmCount(pwmCount),
    .pinIn(pinIn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .flagClr(flagClr),
    .pinOut(pinOut), .irqFlag(irqFlag), .timerReset(timerReset)
  );

  // ---------------- behavioural reference model ----------------
  bit s1 = 0, s2 = 0, sPrev = 0, mPrevEq = 0;
  bit mPin = 0, mFlag = 0, mTr = 0;
  logic [3:0] mMode = 4'h0;
  logic [1:0] mDc = 2'h0;
  logic [15:0] mData = 16'h0;
  logic [9:0] mDuty = 10'h0;
  int mCnt = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      s1 = 0; s2 = 0; sPrev = 0; mPrevEq = 0; mPin = 0; mFlag = 0; mTr = 0;
      mMode = 0; mDc = 0; mData = 0; mDuty = 0; mCnt = 0;
    end else begin
      bit rise, fall, eq, first, cap, setF, nPin, nTr, entry;
      logic [3:0] nm;
      logic [9:0] fresh, useDuty;
      int nCnt, lim;
      rise = s2 && !sPrev;  fall = !s2 && sPrev;
      eq = (timerCount == mData); first = eq && !mPrevEq;
      nm = wrData[3:0];
      entry = wrEn && wrAddr == 0 && nm != mMode;
      cap = 0; setF = 0; nPin = mPin; nTr = 0; nCnt = mCnt;
      lim = (mMode == 4'd6) ? 4 : 16;
      case (mMode)
        4'd0: begin nPin = 0; nCnt = 0; mDuty = 0; end
        4'd2: if (first) begin nPin = !mPin; setF = 1; end
        4'd4: cap = fall;
        4'd5: cap = rise;
        4'd6, 4'd7: if (rise) begin
          if (mCnt == lim - 1) begin cap = 1; nCnt = 0; end else nCnt = mCnt + 1;
        end
        4'd8: if (first) begin nPin = 1; setF = 1; end
        4'd9: if (first) begin nPin = 0; setF = 1; end
        4'd10: if (first) setF = 1;
        4'd11: if (first) begin setF = 1; nTr = 1; end
        4'd12, 4'd13, 4'd14, 4'd15: begin
          fresh = {mData[7:0], mDc};
          useDuty = (pwmCount == 0) ? fresh : mDuty;
          if (pwmCount == 0) mDuty = fresh;
          nPin = pwmCount < useDuty;
        end
        default: ;
      endcase
      if (cap) setF = 1;
      if (entry) begin
        nCnt = 0;
        if (nm == 4'd0 || nm == 4'd8) nPin = 0;
        else if (nm == 4'd9) nPin = 1;
      end
      if (cap) mData = timerCount;
      else if (wrEn && wrAddr == 1) mData[7:0] = wrData;
      else if (wrEn && wrAddr == 2) mData[15:8] = wrData;
      if (setF) mFlag = 1; else if (flagClr) mFlag = 0;
      if (wrEn && wrAddr == 0) begin mMode = nm; mDc = wrData[5:4]; end
      mPin = nPin; mTr = nTr; mCnt = nCnt; mPrevEq = eq;
      sPrev = s2; s2 = s1; s1 = pinIn;
    end
    started = 1;
  end

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    logic [7:0] expRd;
    case (rdAddr)
      2'd0: expRd = {2'b00, mDc, mMode};
      2'd1: expRd = mData[7:0];
      2'd2: expRd = mData[15:8];
      default: expRd = 8'h00;
    endcase
    check("pinOut", pinOut, mPin);
    check("irqFlag", irqFlag, mFlag);
    check("timerReset", timerReset, mTr);
    check("rdData", rdData, expRd);
  end

  // free-running timer, PWM count and read address
  initial forever begin
    @(posedge clk); #1;
    if (!timerHold) timerCount = timerCount + 16'd1;
    pwmCount = (pwmCount == 10'd1023) ? 10'd0 : pwmCount + 10'd1;
    rdAddr = (rdAddr == 2'd2) ? 2'd0 : rdAddr + 2'd1;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1; wrEn = 1; wrAddr = a; wrData = d;
    @(posedge clk); #1; wrEn = 0;
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      pinIn = 1; tick(2); pinIn = 0; tick(2);
    end
  endtask

  task automatic setTarget(logic [15:0] v);
    regWrite(2, v[15:8]); regWrite(1, v[7:0]);
  endtask

  task automatic holdMatch();
    logic [15:0] v;
    v = timerCount + 16'd30;
    setTarget(v);
    @(posedge clk); #1; timerHold = 1; timerCount = v;
    tick(5);
    timerCount = v + 16'd3; tick(2);
    timerCount = v; tick(3);
    timerHold = 0;
  endtask

  initial begin
    rstN = 1'b0;
    tick(4);
    rstN = 1'b1;
    tick(3);                                   // R2 reset state

    curReq = "R1";
    regWrite(0, 8'hF1); regWrite(1, 8'h34); regWrite(2, 8'h12); tick(6);

    curReq = "R3";
    timerHold = 1; timerCount = 16'h1234; pulses(3);
    regWrite(0, 8'h03); pulses(2); timerHold = 0;

    curReq = "R4";
    regWrite(0, 8'h05); pulses(3);
    regWrite(0, 8'h04); pulses(3);
    @(posedge clk); #1; wrEn = 1; wrAddr = 1; wrData = 8'hAA; pinIn = 1; tick(4);
    wrEn = 0; pinIn = 0; tick(2);

    curReq = "R11";
    flagClr = 1; tick(1); flagClr = 0; tick(3);

    curReq = "R5";
    regWrite(0, 8'h06); pulses(9);
    regWrite(0, 8'h07); pulses(5);
    regWrite(0, 8'h06); pulses(4);
    regWrite(0, 8'h07); pulses(34);

    curReq = "R6";
    flagClr = 1; tick(1); flagClr = 0;
    regWrite(0, 8'h02);
    setTarget(timerCount + 16'd40); tick(45);
    setTarget(timerCount + 16'd20); tick(25);

    curReq = "R9";
    holdMatch();

    curReq = "R7";
    regWrite(0, 8'h08); holdMatch();
    regWrite(0, 8'h09); holdMatch();

    curReq = "R8";
    regWrite(0, 8'h0A); flagClr = 1; tick(1); flagClr = 0; holdMatch();
    regWrite(0, 8'h0B); holdMatch();

    curReq = "R11";
    begin
      logic [15:0] v;
      v = timerCount + 16'd20; setTarget(v);
      @(posedge clk); #1; timerHold = 1; timerCount = v; flagClr = 1;
      tick(1); flagClr = 0; tick(3); timerHold = 0;
      flagClr = 1; tick(1); flagClr = 0; tick(2);
    end

    curReq = "R10";
    regWrite(1, 8'h40); regWrite(0, 8'h2C); tick(1100);
    regWrite(1, 8'h10); tick(1100);
    regWrite(0, 8'h3F); tick(300);
    regWrite(1, 8'h00); regWrite(0, 8'h0C); tick(1100);

    curReq = "R2";
    regWrite(0, 8'h00); tick(5); pulses(2);
    setTarget(timerCount + 16'd10); tick(15);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule